// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block gathers a set of interrupt request lines from peripherals and folds them into a single interrupt output toward the processor. Every line has its own trigger mode, edge or level, and its own active sense. A qualifying condition on a line latches a flag bit. Flags are held until software clears them. A per-line block bit keeps a flag from reaching the output, but the flag is still recorded.

Software reaches four word registers through a plain write port and a combinational read port. Offset 0 is the trigger-mode vector: 1 selects edge, 0 selects level. Offset 1 is the sense vector: 1 selects a rising edge or an active-high level, and 0 selects a falling edge or an active-low level. Offset 2 is the block vector, where 1 keeps the line away from the output. Offset 3 holds the flags; it reads as 1 where an event is pending, and writing 1 to a bit clears it. Bit i of every register belongs to request line i. The usual line assignment puts the buffer manager at 0 and the push-button at 13. The one-shot timer, SPI, I2C, PHY, underrun, overrun, PPS, UART receive, UART transmit, serial link, clock status and periodic timer take the lines between them, in that order.

Top module: `irq_aggr_top`

## Requirements
- R1: After reset, offset 0 reads 0, offset 1 reads ones in bits [NUM_LINES-1:0], offset 2 reads 0, offset 3 reads 0, and `irq_out` is 0.
- R2: Writes to offsets 0, 1 and 2 are read back in bits [NUM_LINES-1:0]. Bits at NUM_LINES and above always read 0. A write to one offset changes no other register.
- R3: With trigger mode 1 and sense 1, a 0-to-1 change on a line sets its flag at the next clock edge. Holding the line high after a clear does not set the flag again, and a 1-to-0 change does not set it.
- R4: With trigger mode 1 and sense 0, a 1-to-0 change sets the flag at the next clock edge. Holding the line low after a clear does not set it again, and a 0-to-1 change does not set it.
- R5: With trigger mode 0, the flag is set on every clock edge at which the line sits at its active level, which is high for sense 1 and low for sense 0. A clear while the line is still active therefore leaves the flag set. The flag stays set after the line goes inactive, until it is cleared.
- R6: Writing offset 3 clears each flag whose written bit is 1 and leaves flags under written 0 bits unchanged. Writes to other offsets leave the flags unchanged.
- R7: When a qualifying event and a clear of the same flag fall on the same clock edge, the flag ends up set.
- R8: `irq_out` is 1 exactly when some flag is 1 and its block bit is 0. A block bit does not stop its flag from being set.
- R9: An event on line k sets only flag k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw request lines, synchronous to clk |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset for both read and write |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Read data for `cfg_addr`, combinational |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The bench builds the block with NUM_LINES set to 4 and DATA_W set to 32. With four lines, every line can be driven through all four combinations of trigger mode and sense. Every pairing of the 16 flag patterns with the 16 block patterns can be tried on the output. The upper data bits at that width also make it possible to check that unused bits read as zero.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_TRIG  = 2'd0,
    REG_SENSE = 2'd1,
    REG_BLOCK = 2'd2,
    REG_FLAG  = 2'd3
  } irq_reg_e;

endpackage

// File: rtl/irq_aggr_cfg.sv
module irq_aggr_cfg
  import irq_aggr_pkg::*;
#(
  parameter int                 NUM_LINES = 14,
  parameter logic [NUM_LINES-1:0] SENSE_RST = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [NUM_LINES-1:0] wr_bits,
  output logic [NUM_LINES-1:0] trig_q,
  output logic [NUM_LINES-1:0] sense_q,
  output logic [NUM_LINES-1:0] block_q
);

  irq_reg_e sel;
  assign sel = irq_reg_e'(wr_addr);

  logic hit_trig, hit_sense, hit_block;
  assign hit_trig  = wr_en && (sel == REG_TRIG);
  assign hit_sense = wr_en && (sel == REG_SENSE);
  assign hit_block = wr_en && (sel == REG_BLOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= '0;
      sense_q <= SENSE_RST;
      block_q <= '0;
    end else begin
      if (hit_trig)  trig_q  <= wr_bits;
      if (hit_sense) sense_q <= wr_bits;
      if (hit_block) block_q <= wr_bits;
    end
  end

endmodule

// File: rtl/irq_aggr_detect.sv
module irq_aggr_detect #(
  parameter int NUM_LINES = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic [NUM_LINES-1:0] trig,
  input  logic [NUM_LINES-1:0] sense,
  output logic [NUM_LINES-1:0] hit
);

  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= line_in;
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic rise, fall, edge_ev, level_ev;
    assign rise     = line_in[i] & ~prev_q[i];
    assign fall     = ~line_in[i] & prev_q[i];
    assign edge_ev  = sense[i] ? rise : fall;
    assign level_ev = sense[i] ? line_in[i] : ~line_in[i];
    assign hit[i]   = trig[i] ? edge_ev : level_ev;
  end

endmodule

// File: rtl/irq_aggr_flags.sv
module irq_aggr_flags #(
  parameter int NUM_LINES = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] hit,
  input  logic                 clr_en,
  input  logic [NUM_LINES-1:0] clr_bits,
  output logic [NUM_LINES-1:0] flag_q
);

  logic [NUM_LINES-1:0] clr_mask;
  logic [NUM_LINES-1:0] flag_d;

  assign clr_mask = clr_en ? clr_bits : '0;
  // set has priority over clear on the same edge
  assign flag_d   = (flag_q & ~clr_mask) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
  import irq_aggr_pkg::*;
#(
  parameter int NUM_LINES = 14,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 cfg_we,
  input  logic [REG_AW-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic                 irq_out
);

  localparam logic [NUM_LINES-1:0] SENSE_RST = '1;

  logic [NUM_LINES-1:0] wr_bits;
  logic [NUM_LINES-1:0] trig_q, sense_q, block_q;
  logic [NUM_LINES-1:0] hit, flag_q;
  logic                 flag_wr;

  assign wr_bits = cfg_wdata[NUM_LINES-1:0];
  assign flag_wr = cfg_we && (irq_reg_e'(cfg_addr) == REG_FLAG);

  if (DATA_W > NUM_LINES) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^cfg_wdata[DATA_W-1:NUM_LINES];
  end

  irq_aggr_cfg #(.NUM_LINES(NUM_LINES), .SENSE_RST(SENSE_RST)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_bits (wr_bits),
    .trig_q  (trig_q),
    .sense_q (sense_q),
    .block_q (block_q)
  );

  irq_aggr_detect #(.NUM_LINES(NUM_LINES)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (irq_in),
    .trig    (trig_q),
    .sense   (sense_q),
    .hit     (hit)
  );

  irq_aggr_flags #(.NUM_LINES(NUM_LINES)) u_flg (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .clr_en   (flag_wr),
    .clr_bits (wr_bits),
    .flag_q   (flag_q)
  );

  always_comb begin
    cfg_rdata = '0;
    unique case (irq_reg_e'(cfg_addr))
      REG_TRIG:  cfg_rdata[NUM_LINES-1:0] = trig_q;
      REG_SENSE: cfg_rdata[NUM_LINES-1:0] = sense_q;
      REG_BLOCK: cfg_rdata[NUM_LINES-1:0] = block_q;
      REG_FLAG:  cfg_rdata[NUM_LINES-1:0] = flag_q;
      default:   cfg_rdata = '0;
    endcase
  end

  assign irq_out = |(flag_q & ~block_q);

endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
  import irq_aggr_pkg::*;
#(
  parameter int NUM_LINES = 14,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_in,
  input logic                 cfg_we,
  input logic [REG_AW-1:0]    cfg_addr,
  input logic [DATA_W-1:0]    cfg_wdata,
  input logic [NUM_LINES-1:0] trig,
  input logic [NUM_LINES-1:0] sense,
  input logic [NUM_LINES-1:0] flags,
  input logic [NUM_LINES-1:0] hit,
  input logic                 irq_out
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  logic                 flag_wr;
  logic [NUM_LINES-1:0] level_act;
  logic [NUM_LINES-1:0] wbits;
  assign flag_wr   = cfg_we && (cfg_addr == REG_FLAG);
  assign level_act = ~trig & ~(irq_in ^ sense);
  assign wbits     = cfg_wdata[NUM_LINES-1:0];

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> ((flags & $past(hit)) == $past(hit)));

  assert_level_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> ((flags & $past(level_act)) == $past(level_act)));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && flag_wr) |=> ((flags & $past(wbits & ~hit)) == '0));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !flag_wr) |=> ((flags & $past(flags)) == $past(flags)));

  assert_only_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen |=> ((flags & ~$past(flags) & ~$past(hit)) == '0));

  assert_quiet_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq_out);

endmodule

bind irq_aggr_top irq_aggr_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_in    (irq_in),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .trig      (trig_q),
  .sense     (sense_q),
  .flags     (flag_q),
  .hit       (hit),
  .irq_out   (irq_out)
);

// File: tb/test_irq_aggr_top.sv
`timescale 1ns/1ps
module test_irq_aggr_top;

  localparam int N  = 4;
  localparam int DW = 32;
  localparam logic [N-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_aggr_top #(.NUM_LINES(N), .DATA_W(DW)) i_irq_aggr_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic drive(input logic [N-1:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 trig", v, '0);
    rd(2'd1, v); chk("R1 sense", v, DW'(ALL));
    rd(2'd2, v); chk("R1 block", v, '0);
    rd(2'd3, v); chk("R1 flag", v, '0);
    chk("R1 irq_out", DW'(irq_out), '0);

    // R2 readback, upper bits zero, no cross-talk
    wr(2'd0, 32'hFFFF_FFF5);
    wr(2'd2, 32'hA5A5_A5AA);
    rd(2'd0, v); chk("R2 trig", v, 32'h5);
    rd(2'd2, v); chk("R2 block", v, 32'hA);
    rd(2'd1, v); chk("R2 sense untouched", v, DW'(ALL));
    rd(2'd3, v); chk("R2 flag untouched", v, '0);
    wr(2'd1, 32'h0000_0006);
    rd(2'd1, v); chk("R2 sense", v, 32'h6);
    wr(2'd2, '0);

    // R3/R4/R5/R9 sweep: each line, each trigger mode, each sense
    for (int mode = 0; mode < 2; mode++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int k = 0; k < N; k++) begin
          logic [N-1:0] idle, act;
          string tag;
          tag  = (mode == 1) ? ((pol == 1) ? "R3" : "R4") : "R5";
          idle = (pol == 1) ? '0 : ALL;
          act  = idle ^ (N'(1) << k);
          wr(2'd0, (mode == 1) ? DW'(ALL) : '0);
          wr(2'd1, (pol == 1) ? DW'(ALL) : '0);
          drive(idle);
          wr(2'd3, DW'(ALL));
          rd(2'd3, v); chk({tag, " idle flags"}, v, '0);
          drive(act);
          rd(2'd3, v); chk({tag, " R9 set one line"}, v, DW'(N'(1) << k));
          chk({tag, " R8 out"}, DW'(irq_out), 32'h1);
          wr(2'd3, DW'(N'(1) << k));
          rd(2'd3, v);
          chk({tag, " clear while active"}, v, (mode == 1) ? '0 : DW'(N'(1) << k));
          drive(idle);
          rd(2'd3, v);
          chk({tag, " release"}, v, (mode == 1) ? '0 : DW'(N'(1) << k));
          wr(2'd3, DW'(ALL));
          rd(2'd3, v); chk({tag, " cleared"}, v, '0);
        end
      end
    end

    // rising-edge mode on every line from here on
    wr(2'd0, DW'(ALL));
    wr(2'd1, DW'(ALL));
    drive('0);
    wr(2'd3, DW'(ALL));

    // R7 event and clear on the same edge
    @(negedge clk);
    irq_in = 4'b0001;
    cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 32'h1;
    @(negedge clk);
    cfg_we = 1'b0;
    rd(2'd3, v); chk("R7 set wins", v, 32'h1);
    drive('0);
    wr(2'd3, DW'(ALL));

    // R6 selective clear
    drive(4'b1111);
    rd(2'd3, v); chk("R6 all set", v, 32'hF);
    wr(2'd3, 32'h5);
    rd(2'd3, v); chk("R6 partial clear", v, 32'hA);
    wr(2'd3, 32'h0);
    rd(2'd3, v); chk("R6 zero write", v, 32'hA);
    wr(2'd2, 32'hF);
    wr(2'd0, DW'(ALL));
    rd(2'd3, v); chk("R6 other offsets", v, 32'hA);
    wr(2'd2, '0);
    drive('0);
    wr(2'd3, DW'(ALL));

    // R8 all flag patterns against all block patterns
    for (int p = 0; p < 16; p++) begin
      wr(2'd2, DW'(ALL));
      drive('0);
      wr(2'd3, DW'(ALL));
      drive(N'(p));
      rd(2'd3, v); chk("R8 latched under block", v, DW'(p));
      for (int m = 0; m < 16; m++) begin
        wr(2'd2, DW'(m));
        chk("R8 out", DW'(irq_out), DW'(((p & ~m) & 15) != 0));
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule